// File: doc/BRIEF.md
# Sleep and Interrupt Wake-Up Controller

This block sequences power-down and wake-up for a small microcontroller core. The core's instruction decoder sends a one-cycle pulse when it executes a sleep instruction. The controller then decides whether the sleep really takes place. If it does, the controller halts the core, gates its clock, clears the watchdog and updates the two power-down status bits. When a wake condition arrives, it brings the core back on an instruction-cycle boundary.

Any interrupt source whose enable and flag are both set can wake the core, whatever the global interrupt enable says. A wake source that is already pending when the sleep pulse arrives makes the sleep behave as a no-operation. In that case the status bits and the watchdog are left alone, so software can tell from the power-down bit whether the core actually slept.

The global enable matters only after wake, when it selects what happens next. With the global enable clear, execution continues in-line. With it set, the already fetched instruction executes, then two forced no-operation cycles follow, and the interrupt vector is requested during the first of them. In crystal oscillator mode, an oscillator start-up interval is counted before the core resumes.

The controller owns the four-phase instruction-cycle counter and publishes the current phase. Phase 3 is the last phase of each instruction cycle.

Top module: `slp_wake_ctrl`

## Requirements
- R1: A wake source exists when, for at least one index, both irq_en and irq_flag are 1; a set flag whose enable is 0 does not wake a sleeping core.
- R2: A sleep pulse that arrives while a wake source is pending leaves core_halt at 0 and to_bit and pd_bit unchanged, and it produces no wdt_clear.
- R3: A sleep pulse with no wake source pending raises core_halt and core_clk_off on the next cycle. In that same cycle it sets to_bit to 1, clears pd_bit to 0, and gives a one-cycle wdt_clear pulse.
- R4: While asleep, a wake source wakes the core whether gie is 0 or 1.
- R5: With osc_xtal=1, core_halt stays 1 for at least OST_CYCLES (default 1024) clocks after the wake event. With osc_xtal=0, no start-up interval is counted.
- R6: core_halt falls only at the end of an instruction cycle, so q_phase reads 0 in the first cycle after it falls.
- R7: If gie=1 at resume, force_nop stays 0 for one instruction cycle (4 clocks). It is then 1 for two instruction cycles (8 clocks), with vec_req=1 during the first 4 of them only. If gie=0, neither force_nop nor vec_req is asserted.
- R8: A wdt_timeout pulse clears to_bit to 0 and leaves pd_bit unchanged. A wdt_timeout while asleep also wakes the core.
- R9: After reset, to_bit=1, pd_bit=1, core_halt=0, force_nop=0 and vec_req=0. A clrwdt_exec pulse sets to_bit and pd_bit to 1 and gives one wdt_clear pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_exec | input | 1 | One-cycle pulse: sleep instruction executed |
| clrwdt_exec | input | 1 | One-cycle pulse: watchdog-clear instruction executed |
| irq_en | input | NSRC | Per-source interrupt enables |
| irq_flag | input | NSRC | Per-source interrupt flags |
| gie | input | 1 | Global interrupt enable |
| osc_xtal | input | 1 | 1 = crystal oscillator mode (start-up delay applies) |
| wdt_timeout | input | 1 | One-cycle pulse: watchdog expired |
| q_phase | output | 2 | Current instruction-cycle phase (0..3) |
| core_halt | output | 1 | Core halted |
| core_clk_off | output | 1 | Core clock gated off |
| wdt_clear | output | 1 | Pulse clearing the watchdog and prescaler |
| to_bit | output | 1 | Timeout status bit |
| pd_bit | output | 1 | Power-down status bit |
| force_nop | output | 1 | Core executes a forced no-operation |
| vec_req | output | 1 | Load program counter with the interrupt vector |

## Verification
A wrong sleep-accept decision shows within one clock: core_halt, pd_bit and wdt_clear all move together on the cycle after the sleep pulse, or all fail to move. A corrupted start-up counter shows as a halt duration outside a four-clock window after the OST_CYCLES count. A wrong resume state shows at most twelve clocks after core_halt falls, as a misplaced force_nop or vec_req, or as a q_phase that is not 0 when the core resumes.

// File: rtl/slp_pkg.sv
package slp_pkg;
  typedef enum logic [2:0] {
    ST_AWAKE  = 3'd0,
    ST_ASLEEP = 3'd1,
    ST_OSTART = 3'd2,
    ST_BOUND  = 3'd3,
    ST_FETCHD = 3'd4,
    ST_FNOP_A = 3'd5,
    ST_FNOP_B = 3'd6
  } slp_state_e;

  localparam int unsigned PHASES = 4;
endpackage

// File: rtl/slp_qphase_gen.sv
module slp_qphase_gen #(
  parameter int unsigned PHASES = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  output logic [$clog2(PHASES)-1:0]   phase,
  output logic                        q_end
);
  localparam int unsigned PW = $clog2(PHASES);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic [PW-1:0] phase_q, phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;
  assign q_end = (phase_q == LAST);
endmodule

// File: rtl/slp_ost_timer.sv
module slp_ost_timer #(
  parameter int unsigned OST_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int unsigned OW = $clog2(OST_CYCLES + 1);
  localparam logic [OW-1:0] TERM = OW'(OST_CYCLES - 1);

  logic [OW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run && (cnt_q != TERM);

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && (cnt_q == TERM);
endmodule

// File: rtl/slp_status_bits.sv
module slp_status_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic clrwdt,
  input  logic sleep_go,
  input  logic wdt_to,
  output logic to_bit,
  output logic pd_bit,
  output logic wdt_clr
);
  logic to_q, to_d, pd_q, pd_d, clr_q, clr_d;

  always_comb begin
    to_d  = to_q;
    pd_d  = pd_q;
    clr_d = clrwdt | sleep_go;
    if (clrwdt) begin
      to_d = 1'b1;
      pd_d = 1'b1;
    end else if (sleep_go) begin
      to_d = 1'b1;
      pd_d = 1'b0;
    end else if (wdt_to) begin
      to_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_q  <= 1'b1;
      pd_q  <= 1'b1;
      clr_q <= 1'b0;
    end else begin
      to_q  <= to_d;
      pd_q  <= pd_d;
      clr_q <= clr_d;
    end
  end

  assign to_bit  = to_q;
  assign pd_bit  = pd_q;
  assign wdt_clr = clr_q;
endmodule

// File: rtl/slp_wake_ctrl.sv
module slp_wake_ctrl
  import slp_pkg::*;
#(
  parameter int unsigned NSRC       = 8,
  parameter int unsigned OST_CYCLES = 1024
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_exec,
  input  logic            clrwdt_exec,
  input  logic [NSRC-1:0] irq_en,
  input  logic [NSRC-1:0] irq_flag,
  input  logic            gie,
  input  logic            osc_xtal,
  input  logic            wdt_timeout,
  output logic [1:0]      q_phase,
  output logic            core_halt,
  output logic            core_clk_off,
  output logic            wdt_clear,
  output logic            to_bit,
  output logic            pd_bit,
  output logic            force_nop,
  output logic            vec_req
);
  // Reset: asserted asynchronously, released through two flops
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  logic [1:0] phase;
  logic       q_end;

  slp_qphase_gen #(.PHASES(PHASES)) u_qph (
    .clk   (clk),
    .rst_n (rst_s2),
    .phase (phase),
    .q_end (q_end)
  );

  logic [NSRC-1:0] src_hit;
  logic            wake_pend;
  assign src_hit   = irq_en & irq_flag;
  assign wake_pend = |src_hit;

  slp_state_e st_q, st_d;
  logic       sleep_go, ost_run, ost_done;

  assign sleep_go = (st_q == ST_AWAKE) && sleep_exec && !wake_pend;
  assign ost_run  = (st_q == ST_OSTART);

  slp_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .clk   (clk),
    .rst_n (rst_s2),
    .run   (ost_run),
    .done  (ost_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_AWAKE:  if (sleep_go) st_d = ST_ASLEEP;
      ST_ASLEEP: if (wake_pend || wdt_timeout)
                   st_d = osc_xtal ? ST_OSTART : ST_BOUND;
      ST_OSTART: if (ost_done) st_d = ST_BOUND;
      ST_BOUND:  if (q_end) st_d = gie ? ST_FETCHD : ST_AWAKE;
      ST_FETCHD: if (q_end) st_d = ST_FNOP_A;
      ST_FNOP_A: if (q_end) st_d = ST_FNOP_B;
      ST_FNOP_B: if (q_end) st_d = ST_AWAKE;
      default:   st_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s2) begin
    if (!rst_s2) st_q <= ST_AWAKE;
    else         st_q <= st_d;
  end

  slp_status_bits u_stat (
    .clk      (clk),
    .rst_n    (rst_s2),
    .clrwdt   (clrwdt_exec),
    .sleep_go (sleep_go),
    .wdt_to   (wdt_timeout),
    .to_bit   (to_bit),
    .pd_bit   (pd_bit),
    .wdt_clr  (wdt_clear)
  );

  assign q_phase      = phase;
  assign core_clk_off = (st_q == ST_ASLEEP) || (st_q == ST_OSTART);
  assign core_halt    = core_clk_off || (st_q == ST_BOUND);
  assign force_nop    = (st_q == ST_FNOP_A) || (st_q == ST_FNOP_B);
  assign vec_req      = (st_q == ST_FNOP_A);
endmodule

// File: rtl/slp_wake_ctrl_chk.sv
module slp_wake_ctrl_chk #(
  parameter int unsigned NSRC = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sleep_exec,
  input logic            clrwdt_exec,
  input logic [NSRC-1:0] irq_en,
  input logic [NSRC-1:0] irq_flag,
  input logic            wdt_timeout,
  input logic [1:0]      q_phase,
  input logic            core_halt,
  input logic            wdt_clear,
  input logic            to_bit,
  input logic            pd_bit,
  input logic            force_nop,
  input logic            vec_req
);
  logic pend;
  assign pend = |(irq_en & irq_flag);

  AST_SLEEP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exec && !pend && !core_halt && !force_nop && !clrwdt_exec) |=> (core_halt && !pd_bit && wdt_clear)); // R3
  AST_NOP_SLEEP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep_exec && pend && !core_halt && !clrwdt_exec && !wdt_timeout) |=> ($stable(pd_bit) && $stable(to_bit))); // R2
  AST_RESUME_ON_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_halt) |-> (q_phase == 2'd0)); // R6
  AST_VEC_IN_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    vec_req |-> (force_nop && !core_halt)); // R7
  AST_HALT_PD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_halt) |-> !pd_bit); // R3
  AST_TIMEOUT_TO: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_timeout && !clrwdt_exec && !sleep_exec) |=> (!to_bit && $stable(pd_bit))); // R8
endmodule

bind slp_wake_ctrl slp_wake_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk         (clk),
  .rst_n       (rst_s2),
  .sleep_exec  (sleep_exec),
  .clrwdt_exec (clrwdt_exec),
  .irq_en      (irq_en),
  .irq_flag    (irq_flag),
  .wdt_timeout (wdt_timeout),
  .q_phase     (q_phase),
  .core_halt   (core_halt),
  .wdt_clear   (wdt_clear),
  .to_bit      (to_bit),
  .pd_bit      (pd_bit),
  .force_nop   (force_nop),
  .vec_req     (vec_req)
);

// File: tb/sim_slp_wake_ctrl.sv
`timescale 1ns/1ps
module sim_slp_wake_ctrl;
  localparam int NSRC = 8;
  localparam int OST  = 1024;

  logic clk = 1'b0;
  logic rst_n, sleep_exec, clrwdt_exec, gie, osc_xtal, wdt_timeout;
  logic [NSRC-1:0] irq_en, irq_flag;
  logic [1:0] q_phase;
  logic core_halt, core_clk_off, wdt_clear, to_bit, pd_bit, force_nop, vec_req;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  slp_wake_ctrl #(.NSRC(NSRC), .OST_CYCLES(OST)) u0 (
    .clk(clk), .rst_n(rst_n), .sleep_exec(sleep_exec), .clrwdt_exec(clrwdt_exec),
    .irq_en(irq_en), .irq_flag(irq_flag), .gie(gie), .osc_xtal(osc_xtal),
    .wdt_timeout(wdt_timeout), .q_phase(q_phase), .core_halt(core_halt),
    .core_clk_off(core_clk_off), .wdt_clear(wdt_clear), .to_bit(to_bit),
    .pd_bit(pd_bit), .force_nop(force_nop), .vec_req(vec_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_exec = 1'b1; tick(1); sleep_exec = 1'b0;
  endtask

  // wait until core_halt is 0, returns negedges waited
  task automatic wait_resume(output int n);
    n = 0;
    while (core_halt && n < 3000) begin tick(1); n++; end
  endtask

  task automatic t_reset();
    check(to_bit == 1 && pd_bit == 1, "R9 reset status", {to_bit, pd_bit}, 3);
    check(core_halt == 0 && force_nop == 0 && vec_req == 0, "R9 reset outputs",
          {core_halt, force_nop, vec_req}, 0);
  endtask

  task automatic t_nop_sleep();
    irq_en = 8'h10; irq_flag = 8'h10;
    pulse_sleep();
    check(core_halt == 0, "R2 halt after pending sleep", core_halt, 0);
    check(pd_bit == 1 && to_bit == 1, "R2 status kept", {to_bit, pd_bit}, 3);
    check(wdt_clear == 0, "R2 no watchdog clear", wdt_clear, 0);
    irq_flag = '0; tick(2);
  endtask

  task automatic t_sleep_rc_gie0();
    int n;
    osc_xtal = 1'b0; gie = 1'b0; irq_en = 8'h01; irq_flag = '0;
    pulse_sleep();
    check(core_halt == 1 && core_clk_off == 1, "R3 halt and gate", {core_halt, core_clk_off}, 3);
    check(pd_bit == 0 && to_bit == 1, "R3 status on sleep", {to_bit, pd_bit}, 2);
    check(wdt_clear == 1, "R3 watchdog clear pulse", wdt_clear, 1);
    tick(1);
    check(wdt_clear == 0, "R3 clear is one cycle", wdt_clear, 0);
    irq_flag = 8'h02; tick(20);
    check(core_halt == 1, "R1 flag without enable stays asleep", core_halt, 1);
    irq_flag = 8'h03;
    wait_resume(n);
    check(n >= 1 && n <= 5, "R4 R5 wake with gie=0, no start-up delay", n, 5);
    check(q_phase == 2'd0, "R6 resume phase", q_phase, 0);
    irq_flag = '0;
    for (int i = 0; i < 14; i++) begin
      if (force_nop || vec_req)
        check(0, "R7 no forced nop with gie=0", {force_nop, vec_req}, 0);
      tick(1);
    end
    check(force_nop == 0 && vec_req == 0, "R7 inline continue", {force_nop, vec_req}, 0);
  endtask

  task automatic t_sleep_xtal_gie1();
    int n;
    osc_xtal = 1'b1; gie = 1'b1; irq_en = 8'h80; irq_flag = '0;
    pulse_sleep(); tick(3);
    irq_flag = 8'h80;
    wait_resume(n);
    check(n >= OST + 2 && n <= OST + 5, "R5 start-up delay length", n, OST + 2);
    check(q_phase == 2'd0, "R6 resume phase after start-up", q_phase, 0);
    irq_flag = '0;
    for (int i = 0; i < 4; i++) begin
      check(force_nop == 0 && vec_req == 0, "R7 fetched instruction cycle", {force_nop, vec_req}, 0);
      tick(1);
    end
    for (int i = 0; i < 4; i++) begin
      check(force_nop == 1 && vec_req == 1, "R7 first forced nop with vector", {force_nop, vec_req}, 3);
      tick(1);
    end
    for (int i = 0; i < 4; i++) begin
      check(force_nop == 1 && vec_req == 0, "R7 second forced nop", {force_nop, vec_req}, 2);
      tick(1);
    end
    check(force_nop == 0 && core_halt == 0, "R7 back to normal", {force_nop, core_halt}, 0);
  endtask

  task automatic t_wdt_wake();
    int n;
    osc_xtal = 1'b0; gie = 1'b0; irq_en = '0; irq_flag = '0;
    pulse_sleep(); tick(3);
    wdt_timeout = 1'b1; tick(1); wdt_timeout = 1'b0;
    check(to_bit == 0 && pd_bit == 0, "R8 timeout while asleep", {to_bit, pd_bit}, 0);
    wait_resume(n);
    check(n <= 5, "R8 timeout wakes core", n, 5);
  endtask

  task automatic t_clrwdt_and_awake_to();
    clrwdt_exec = 1'b1; tick(1); clrwdt_exec = 1'b0;
    check(to_bit == 1 && pd_bit == 1, "R9 clrwdt sets bits", {to_bit, pd_bit}, 3);
    check(wdt_clear == 1, "R9 clrwdt clears watchdog", wdt_clear, 1);
    tick(1);
    wdt_timeout = 1'b1; tick(1); wdt_timeout = 1'b0;
    check(to_bit == 0 && pd_bit == 1, "R8 timeout awake keeps pd", {to_bit, pd_bit}, 1);
    check(core_halt == 0, "R8 awake timeout no halt", core_halt, 0);
  endtask

  initial begin
    rst_n = 1'b0; sleep_exec = 0; clrwdt_exec = 0; gie = 0; osc_xtal = 0;
    wdt_timeout = 0; irq_en = '0; irq_flag = '0;
    tick(3); rst_n = 1'b1; tick(4);
    t_reset();
    t_nop_sleep();
    t_sleep_rc_gie0();
    t_sleep_xtal_gie1();
    t_wdt_wake();
    t_clrwdt_and_awake_to();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 20000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule